// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Carry-Save Reduction Tree

This block multiplies two signed two's-complement integers of a configurable width N and returns the full 2N-bit signed product. The multiplier operand is recoded into radix-4 signed digits. Each digit is in the set {0, +1, +2, -1, -2}. Each digit selects a shifted copy of the multiplicand, or its one's complement. This gives one partial-product row per digit pair. The rows, plus one row that collects the +1 corrections for the negative digits, are reduced by a tree of 3:2 full-adder levels. The reduction stops when two rows remain. A single carry-propagate adder then sums those two rows.

A parameter bit mask places pipeline registers after chosen compression levels. The latency therefore ranges from zero cycles (fully combinational) up to one cycle per tree level. A pipelined instance takes a new operand pair on every cycle. An odd N is handled by sign-extending both operands by one bit inside the block. The external widths and the product stay at N and 2N.

Top module: `booth_wallace_mul`

## Requirements
- R1: For every pair of signed N-bit operands a and b, `product` equals the signed product a*b as a 2N-bit two's-complement value.
- R2: `out_valid` equals `in_valid` delayed by L cycles. L is the number of set bits of `PIPE_MASK` among positions 0 to LVL-1, where LVL is the number of compression levels and bit k registers the output of level k. `product` belongs to the operand pair sampled L cycles earlier.
- R3: With `PIPE_MASK` zero, the block is purely combinational. `out_valid` and `product` follow the inputs within the same cycle.
- R4: The most negative value times itself gives +2^(2N-2), a positive result.
- R5: The most negative value times -1 gives +2^(N-1), with no overflow or sign error.
- R6: A zero in either operand gives a product of zero, whatever the sign of the other operand.
- R7: A pipelined instance accepts one operation per cycle. Back-to-back valid inputs each produce their own correct result, in issue order.
- R8: While `rst_n` is low, every pipeline valid bit is cleared. `out_valid` is low on the cycle after reset is sampled, for any instance with L > 0.
- R9: An odd N gives correct signed products in all cases, through a one-bit internal sign extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Synchronous active-low reset of the valid bits |
| in_valid | input | 1 | Operand pair on a and b is valid |
| a | input | N | Signed multiplicand |
| b | input | N | Signed multiplier, Booth-recoded |
| out_valid | output | 1 | product carries a valid result |
| product | output | 2N | Signed product a*b |

## Verification
The sweeps cover all operand pairs of a small even width in a registered configuration, and all pairs of a small odd width in the combinational configuration. Every Booth digit, including the -2 digit produced by the top bit of a negative multiplier, meets every multiplicand, so a wrong recoding entry or a missing correction bit shows up as an off-by-multiplicand error. The most negative value times itself and times -1 are called out: if the sign extension of the rows is lost, or carries are truncated before 2N bits, these results come out negative or wrapped. Random idle gaps in the stream check that the valid bit and the data travel through the same registers, so a stage count that does not match the mask shows up as misaligned results.

// File: rtl/mul_pkg.sv
package mul_pkg;

   // Rows left after one 3:2 compression level acting on r rows
   function automatic int rows_next(input int r);
      return 2 * (r / 3) + (r % 3);
   endfunction

   // Rows present at the input of level l (l = 0 is the partial-product set)
   function automatic int rows_at(input int r0, input int l);
      int r;
      r = r0;
      for (int i = 0; i < l; i++) r = rows_next(r);
      return r;
   endfunction

   // Number of levels needed until two rows remain
   function automatic int num_levels(input int r0);
      int r;
      int n;
      r = r0;
      n = 0;
      while (r > 2) begin
         r = rows_next(r);
         n++;
      end
      return n;
   endfunction

   // Count of register stages selected by mask among the first lvl levels
   function automatic int stage_count(input logic [15:0] mask, input int lvl);
      int n;
      n = 0;
      for (int i = 0; i < lvl; i++) if (mask[i]) n++;
      return n;
   endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
   parameter int NE = 8,
   localparam int PW = 2 * NE,
   localparam int ND = NE / 2
) (
   input  logic [NE-1:0]          a_x,
   input  logic [NE-1:0]          b_x,
   output logic [ND:0][PW-1:0]    rows
);

   logic [PW-1:0] mag1;
   logic [NE:0]   bpad;
   logic [ND-1:0] neg_v;

   assign mag1 = PW'($signed(a_x));
   assign bpad = {b_x, 1'b0};

   for (genvar i = 0; i < ND; i++) begin : g_digit
      logic [2:0]    trip;
      logic [PW-1:0] mag;
      logic          neg;
      assign trip = bpad[2*i+2 -: 3];
      always_comb begin
         mag = '0;
         neg = 1'b0;
         unique case (trip)
            3'b001, 3'b010: mag = mag1;
            3'b011:         mag = mag1 << 1;
            3'b100: begin mag = mag1 << 1; neg = 1'b1; end
            3'b101, 3'b110: begin mag = mag1; neg = 1'b1; end
            default:        mag = '0;
         endcase
      end
      assign rows[i]  = (neg ? ~mag : mag) << (2 * i);
      assign neg_v[i] = neg;
   end

   // Row of +1 corrections completing the two's complement of negative digits
   always_comb begin
      rows[ND] = '0;
      for (int i = 0; i < ND; i++) rows[ND][2*i] = neg_v[i];
   end

endmodule

// File: rtl/csa_level.sv
module csa_level #(
   parameter int RIN = 3,
   parameter int PW  = 16,
   localparam int NG   = RIN / 3,
   localparam int ROUT = 2 * NG + (RIN % 3)
) (
   input  logic [RIN-1:0][PW-1:0]  din,
   output logic [ROUT-1:0][PW-1:0] dout
);

   for (genvar g = 0; g < NG; g++) begin : g_fa
      logic [PW-1:0] x, y, z;
      assign x = din[3*g];
      assign y = din[3*g+1];
      assign z = din[3*g+2];
      assign dout[2*g]   = x ^ y ^ z;
      assign dout[2*g+1] = ((x & y) | (x & z) | (y & z)) << 1;
   end

   for (genvar k = 0; k < RIN % 3; k++) begin : g_pass
      assign dout[2*NG+k] = din[3*NG+k];
   end

endmodule

// File: rtl/pipe_reg.sv
module pipe_reg #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vd,
   input  logic [W-1:0] dd,
   output logic         vq,
   output logic [W-1:0] dq
);

   if (EN) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) vq <= 1'b0;
         else        vq <= vd;
      end
      always_ff @(posedge clk) dq <= dd;
   end else begin : g_wire
      assign vq = vd;
      assign dq = dd;
   end

endmodule

// File: rtl/booth_wallace_mul.sv
module booth_wallace_mul
   import mul_pkg::*;
#(
   parameter int          N         = 8,
   parameter logic [15:0] PIPE_MASK = 16'h0005
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic           out_valid,
   output logic [2*N-1:0] product
);

   localparam int NE  = N + (N % 2);
   localparam int PW  = 2 * NE;
   localparam int ND  = NE / 2;
   localparam int R0  = ND + 1;
   localparam int LVL = num_levels(R0);
   localparam int LAT = stage_count(PIPE_MASK, LVL);

   if (N < 4) begin : g_bad_width
      $error("booth_wallace_mul: N must be at least 4");
   end
   if (LVL > 16) begin : g_bad_depth
      $error("booth_wallace_mul: tree deeper than PIPE_MASK can describe");
   end
   if (LVL < 16) begin : g_mask_chk
      if ((PIPE_MASK >> LVL) != 16'h0) begin : g_bad_mask
         $error("booth_wallace_mul: PIPE_MASK selects a level that does not exist");
      end
   end

   logic [NE-1:0]        a_x, b_x;
   logic [R0-1:0][PW-1:0] pp;

   assign a_x = NE'($signed(a));
   assign b_x = NE'($signed(b));

   booth_pp_gen #(.NE(NE)) u_pp (
      .a_x  (a_x),
      .b_x  (b_x),
      .rows (pp)
   );

   for (genvar l = 0; l < LVL; l++) begin : g_lvl
      localparam int RI = rows_at(R0, l);
      localparam int RO = rows_at(R0, l + 1);
      logic [RI-1:0][PW-1:0] lin;
      logic                  vin;
      logic [RO-1:0][PW-1:0] cs;
      logic [RO-1:0][PW-1:0] q;
      logic                  vq;

      if (l == 0) begin : g_first
         assign lin = pp;
         assign vin = in_valid;
      end else begin : g_next
         assign lin = g_lvl[l-1].q;
         assign vin = g_lvl[l-1].vq;
      end

      csa_level #(.RIN(RI), .PW(PW)) u_csa (
         .din  (lin),
         .dout (cs)
      );

      pipe_reg #(.W(RO * PW), .EN(PIPE_MASK[l])) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .vd    (vin),
         .dd    (cs),
         .vq    (vq),
         .dq    (q)
      );
   end

   logic [PW-1:0] sum;
   assign sum       = g_lvl[LVL-1].q[0] + g_lvl[LVL-1].q[1];
   assign product   = sum[2*N-1:0];
   assign out_valid = g_lvl[LVL-1].vq;

endmodule

// File: rtl/mul_chk.sv
module mul_chk
   import mul_pkg::*;
#(
   parameter int          N         = 8,
   parameter logic [15:0] PIPE_MASK = 16'h0005
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic [N-1:0]   a,
   input logic [N-1:0]   b,
   input logic           out_valid,
   input logic [2*N-1:0] product
);

   localparam int NE  = N + (N % 2);
   localparam int LVL = num_levels(NE / 2 + 1);
   localparam int LAT = stage_count(PIPE_MASK, LVL);

   logic         ev [0:LAT];
   logic [N-1:0] ea [0:LAT];
   logic [N-1:0] eb [0:LAT];

   assign ev[0] = in_valid;
   assign ea[0] = a;
   assign eb[0] = b;

   always_ff @(posedge clk) begin
      for (int i = 1; i <= LAT; i++) begin
         ev[i] <= rst_n ? ev[i-1] : 1'b0;
         ea[i] <= ea[i-1];
         eb[i] <= eb[i-1];
      end
   end

   logic signed [2*N-1:0] exp_p;
   logic [N-1:0]          minv;
   assign exp_p = $signed(ea[LAT]) * $signed(eb[LAT]);
   assign minv  = {1'b1, {(N-1){1'b0}}};

   // R1 and R9: result matches the arithmetic product of the aligned operands
   p_prod_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (product == exp_p));

   // R2: valid travels with the data through the selected stages
   p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == ev[LAT]);

   p_min_sq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ea[LAT] == minv && eb[LAT] == minv)
      |-> (product == (2*N)'(1) << (2*N-2)));

   p_min_neg1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ea[LAT] == minv && eb[LAT] == {N{1'b1}})
      |-> (product == (2*N)'(1) << (N-1)));

   p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (ea[LAT] == '0 || eb[LAT] == '0)) |-> (product == '0));

   if (LAT > 0) begin : g_rst_chk
      p_reset_clear_r8: assert property (@(posedge clk)
         !rst_n |=> !out_valid);
   end

endmodule

bind booth_wallace_mul mul_chk #(.N(N), .PIPE_MASK(PIPE_MASK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .a         (a),
   .b         (b),
   .out_valid (out_valid),
   .product   (product)
);

// File: tb/booth_wallace_mul_tb_top.sv
`timescale 1ns/1ps
module booth_wallace_mul_tb_top;

   // Registered instance: N=6 has two compression levels; mask 3 registers both (latency 2)
   localparam int NP  = 6;
   localparam int LP  = 2;
   // Combinational instance with odd width
   localparam int NC  = 5;
   localparam int LOGN = 16384;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            pv = 1'b0;
   logic [NP-1:0]   pa = '0, pb = '0;
   logic            pov;
   logic [2*NP-1:0] pprod;

   logic            cv = 1'b0;
   logic [NC-1:0]   ca = '0, cb = '0;
   logic            cov;
   logic [2*NC-1:0] cprod;

   booth_wallace_mul #(.N(NP), .PIPE_MASK(16'h0003)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(pv), .a(pa), .b(pb),
      .out_valid(pov), .product(pprod)
   );

   booth_wallace_mul #(.N(NC), .PIPE_MASK(16'h0000)) dut_c (
      .clk(clk), .rst_n(rst_n), .in_valid(cv), .a(ca), .b(cb),
      .out_valid(cov), .product(cprod)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic          lv [0:LOGN-1];
   logic [NP-1:0] la [0:LOGN-1];
   logic [NP-1:0] lb [0:LOGN-1];
   int t = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic string tag(input longint x, input longint y, input int n);
      longint mn;
      mn = -(longint'(1) << (n - 1));
      if (x == mn && y == mn) return "R4";
      if (x == mn && y == -1) return "R5";
      if (x == 0 || y == 0)   return "R6";
      return "R1";
   endfunction

   // One cycle of the registered stream: check, then drive
   task automatic step(input bit v, input logic [NP-1:0] x, input logic [NP-1:0] y);
      longint ex, ac;
      @(negedge clk);
      if (t >= LP) begin
         check(pov == lv[t-LP], "R2", longint'(pov), longint'(lv[t-LP]));
         if (lv[t-LP]) begin
            ex = longint'($signed(la[t-LP])) * longint'($signed(lb[t-LP]));
            ac = longint'($signed(pprod));
            check(ac == ex, {tag(longint'($signed(la[t-LP])), longint'($signed(lb[t-LP])), NP), "/R7"}, ac, ex);
         end
      end else begin
         check(pov == 1'b0, "R8", longint'(pov), 0);
      end
      pv = v; pa = x; pb = y;
      lv[t] = v; la[t] = x; lb[t] = y;
      t++;
   endtask

   initial begin
      repeat (4) begin
         @(negedge clk);
         check(pov == 1'b0, "R8", longint'(pov), 0);
      end
      rst_n = 1'b1;

      // R1, R2, R4..R7: all operand pairs, streamed with random idle gaps
      for (int i = 0; i < (1 << NP); i++) begin
         for (int j = 0; j < (1 << NP); j++) begin
            if (($urandom % 4) == 0) step(1'b0, NP'($urandom), NP'($urandom));
            step(1'b1, NP'(i), NP'(j));
         end
      end
      for (int k = 0; k < LP + 2; k++) step(1'b0, '0, '0);

      // R3, R9: odd-width combinational instance, every pair
      for (int i = 0; i < (1 << NC); i++) begin
         for (int j = 0; j < (1 << NC); j++) begin
            longint ex, ac;
            @(negedge clk);
            cv = 1'b1; ca = NC'(i); cb = NC'(j);
            #1;
            ex = longint'($signed(ca)) * longint'($signed(cb));
            ac = longint'($signed(cprod));
            check(cov == 1'b1, "R3", longint'(cov), 1);
            check(ac == ex, {tag(longint'($signed(ca)), longint'($signed(cb)), NC), "/R9"}, ac, ex);
         end
      end
      @(negedge clk);
      cv = 1'b0;
      #1;
      check(cov == 1'b0, "R3", longint'(cov), 0);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule